// File: doc/BRIEF.md
# I2C Target Clock-Stretch Controller

This block sits inside an I2C target and decides when the target pulls SCL low to hold the bus. It counts the falling SCL edges of each nine-bit frame (eight data bits plus the acknowledge bit). At the eighth edge and at the ninth edge it checks a set of hold sources. When any of them applies, it drives an open-drain pull-low request and sets a shared hold flag. SCL stays low until software clears that flag with a strobe.

There are four hold sources, and each has its own enable:
- **Buffer-driven hold.** Applies at the eighth edge when the receive buffer is full or the transmit buffer is empty. A single global disable turns it off.
- **Address hold.** Applies at the eighth edge of a frame whose address matched.
- **Write-data hold.** Applies at the eighth edge of a received write-data byte.
- **Acknowledge-time hold.** Applies at the ninth edge of every frame.

The last three sources each set an event flag of their own and a common interrupt flag. An event source cannot hold again until software has cleared its own event flag.

The shift register, the address comparator and the START/STOP detector are outside this block. Their results arrive as single-cycle edge strobes and level inputs. On a match, the block captures the address byte. An address-location select decides where it goes: into a dedicated address register, or into the receive-buffer view.

Top module: `sh_stretch_ctrl`

## Requirements
- R1: `bit_cnt` returns to 0 on `start_evt` (START or repeated START). Each counted `scl_fall` adds one. After 9 the next counted edge gives 1.
- R2: Buffer-driven hold. With `stretch_dis`=0, a counted fall that brings `bit_cnt` to 8 while `rx_full`=1 or `tx_empty`=1 sets `scl_pull_low` and `hold_flag`. No event flag and no `irq_flag` are set. With `stretch_dis`=1 this source never holds.
- R3: Address hold. With `addr_hold_en`=1 and `addr_match`=1 at the fall that brings `bit_cnt` to 8, the block holds and sets `addr_flag` and `irq_flag`. With `addr_hold_en`=0 it neither holds nor flags.
- R4: Write-data hold. With `wr_hold_en`=1 and `wr_byte`=1 at the fall that brings `bit_cnt` to 8, the block holds and sets `wr_flag` and `irq_flag`.
- R5: Acknowledge-time hold. With `ack_hold_en`=1 the block does not hold at edge 8. At the fall that brings `bit_cnt` to 9 it holds and sets `ack_flag` and `irq_flag`.
- R6: Once set, `scl_pull_low` and `hold_flag` stay 1 until a `clr_hold` strobe (or a STOP), however many cycles pass. Clearing the hold leaves the event flags as they were.
- R7: While an event flag is still 1, its own source does not hold again.
- R8: On a match at edge 8, `shift_byte` is captured. With `addr_sel`=0 it goes into `addr_reg`; with `addr_sel`=1 it goes into `rxb_addr`. The other register keeps its value.
- R9: A `scl_fall` is not counted while the hold is active, nor after release until an `scl_rise` has been seen.
- R10: When several sources apply at the same edge, one hold is applied and every matching flag is set.
- R11: `stop_evt` clears the hold and drives `bit_cnt` to 0.
- R12: Each clear strobe (`clr_addr`, `clr_wr`, `clr_ack`, `clr_irq`) clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_fall | input | 1 | Synchronized SCL falling-edge strobe |
| scl_rise | input | 1 | Synchronized SCL rising-edge strobe |
| start_evt | input | 1 | START or repeated START strobe |
| stop_evt | input | 1 | STOP strobe |
| rx_full | input | 1 | Receive buffer full |
| tx_empty | input | 1 | Transmit buffer empty |
| addr_match | input | 1 | Current frame carries a matching address |
| wr_byte | input | 1 | Current frame is a received write-data byte |
| shift_byte | input | DATA_W | Byte assembled by the shifter |
| stretch_dis | input | 1 | 1 disables buffer-driven hold |
| addr_hold_en | input | 1 | Address hold enable |
| wr_hold_en | input | 1 | Write-data hold enable |
| ack_hold_en | input | 1 | Acknowledge-time hold enable |
| addr_sel | input | 1 | Address capture target: 0 address register, 1 receive-buffer view |
| clr_hold | input | 1 | Software strobe releasing the hold |
| clr_addr | input | 1 | Clears addr_flag |
| clr_wr | input | 1 | Clears wr_flag |
| clr_ack | input | 1 | Clears ack_flag |
| clr_irq | input | 1 | Clears irq_flag |
| scl_pull_low | output | 1 | Open-drain request to drive SCL low |
| hold_flag | output | 1 | Shared hold flag |
| addr_flag | output | 1 | Address event flag |
| wr_flag | output | 1 | Write-data event flag |
| ack_flag | output | 1 | Acknowledge-time event flag |
| irq_flag | output | 1 | Common interrupt flag |
| bit_cnt | output | CW | Counted falling edges in the current frame |
| addr_reg | output | DATA_W | Captured address (select 0) |
| rxb_addr | output | DATA_W | Captured address in receive-buffer view (select 1) |

## Verification
Every result is a single register stage away from its cause, so each is due exactly one clock after the strobe or level that produces it:
- the counter step;
- the hold and flag set at edge 8 or edge 9;
- the release on `clr_hold` or STOP;
- the address capture.

The bench drives each strobe for one cycle starting at a falling clock edge. It samples at the next falling clock edge, which is half a period after the rising edge that updates the registers. Checks that something is ignored are made at that same point: after a blocked fall, a disabled source or a still-set flag, the bench confirms that `bit_cnt` or the hold output is unchanged.

// File: rtl/sh_pkg.sv
package sh_pkg;
    localparam int FRAME_LEN = 9;
    localparam int DATA_W    = 8;

    // Which hold points fired on one counted edge
    typedef struct packed {
        logic buf_hit;
        logic adr_hit;
        logic wr_hit;
        logic ack_hit;
    } hold_src_t;

    // Per-source software-visible event flags
    typedef struct packed {
        logic adr;
        logic wr;
        logic ack;
    } evt_flags_t;

    // Controls sampled by the hold decision
    typedef struct packed {
        logic stretch_dis;
        logic addr_hold_en;
        logic wr_hold_en;
        logic ack_hold_en;
    } hold_cfg_t;

    function automatic logic src_any(hold_src_t s);
        return s.buf_hit | s.adr_hit | s.wr_hit | s.ack_hit;
    endfunction

    function automatic logic src_event(hold_src_t s);
        return s.adr_hit | s.wr_hit | s.ack_hit;
    endfunction
endpackage

// File: rtl/sh_frame_cnt.sv
module sh_frame_cnt #(
    parameter int FRAME_LEN = sh_pkg::FRAME_LEN,
    localparam int CW = $clog2(FRAME_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_fall,
    input  logic          scl_rise,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          holding,
    input  logic          release_now,
    output logic [CW-1:0] cnt,
    output logic          hit_data,
    output logic          hit_ack
);
    localparam logic [CW-1:0] LAST     = CW'(FRAME_LEN);
    localparam logic [CW-1:0] DATA_END = CW'(FRAME_LEN - 1);

    logic          wait_rise;
    logic          counted;
    logic [CW-1:0] cnt_nx;

    assign counted  = scl_fall && !holding && !wait_rise && !start_evt && !stop_evt;
    assign cnt_nx   = (cnt == LAST) ? CW'(1) : cnt + CW'(1);
    assign hit_data = counted && (cnt_nx == DATA_END);
    assign hit_ack  = counted && (cnt_nx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            wait_rise <= 1'b0;
        end else begin
            if (start_evt || stop_evt)
                cnt <= '0;
            else if (counted)
                cnt <= cnt_nx;

            if (stop_evt)
                wait_rise <= 1'b0;
            else if (release_now)
                wait_rise <= 1'b1;
            else if (scl_rise)
                wait_rise <= 1'b0;
        end
    end
endmodule

// File: rtl/sh_hold_decide.sv
module sh_hold_decide
    import sh_pkg::*;
(
    input  logic       hit_data,
    input  logic       hit_ack,
    input  hold_cfg_t  cfg,
    input  logic       rx_full,
    input  logic       tx_empty,
    input  logic       addr_match,
    input  logic       wr_byte,
    input  evt_flags_t flags,
    output hold_src_t  src
);
    always_comb begin
        src.buf_hit = hit_data && !cfg.stretch_dis && (rx_full || tx_empty);
        src.adr_hit = hit_data && cfg.addr_hold_en && addr_match && !flags.adr;
        src.wr_hit  = hit_data && cfg.wr_hold_en && wr_byte && !flags.wr;
        src.ack_hit = hit_ack && cfg.ack_hold_en && !flags.ack;
    end
endmodule

// File: rtl/sh_flag_bank.sv
module sh_flag_bank
    import sh_pkg::*;
#(
    parameter int DATA_W = sh_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  hold_src_t         src,
    input  logic              stop_evt,
    input  logic              clr_hold,
    input  logic              clr_addr,
    input  logic              clr_wr,
    input  logic              clr_ack,
    input  logic              clr_irq,
    input  logic              cap_en,
    input  logic              addr_sel,
    input  logic [DATA_W-1:0] shift_byte,
    output logic              hold_q,
    output evt_flags_t        flags,
    output logic              irq_q,
    output logic [DATA_W-1:0] addr_reg,
    output logic [DATA_W-1:0] rxb_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            flags    <= '0;
            irq_q    <= 1'b0;
            addr_reg <= '0;
            rxb_addr <= '0;
        end else begin
            if (stop_evt)
                hold_q <= 1'b0;
            else if (src_any(src))
                hold_q <= 1'b1;
            else if (clr_hold)
                hold_q <= 1'b0;

            if (src.adr_hit)    flags.adr <= 1'b1;
            else if (clr_addr)  flags.adr <= 1'b0;
            if (src.wr_hit)     flags.wr  <= 1'b1;
            else if (clr_wr)    flags.wr  <= 1'b0;
            if (src.ack_hit)    flags.ack <= 1'b1;
            else if (clr_ack)   flags.ack <= 1'b0;

            if (src_event(src)) irq_q <= 1'b1;
            else if (clr_irq)   irq_q <= 1'b0;

            if (cap_en) begin
                if (addr_sel) rxb_addr <= shift_byte;
                else          addr_reg <= shift_byte;
            end
        end
    end
endmodule

// File: rtl/sh_stretch_ctrl.sv
module sh_stretch_ctrl
    import sh_pkg::*;
#(
    parameter int FRAME_LEN = sh_pkg::FRAME_LEN,
    parameter int DATA_W    = sh_pkg::DATA_W,
    localparam int CW = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_fall,
    input  logic              scl_rise,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              addr_match,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] shift_byte,
    input  logic              stretch_dis,
    input  logic              addr_hold_en,
    input  logic              wr_hold_en,
    input  logic              ack_hold_en,
    input  logic              addr_sel,
    input  logic              clr_hold,
    input  logic              clr_addr,
    input  logic              clr_wr,
    input  logic              clr_ack,
    input  logic              clr_irq,
    output logic              scl_pull_low,
    output logic              hold_flag,
    output logic              addr_flag,
    output logic              wr_flag,
    output logic              ack_flag,
    output logic              irq_flag,
    output logic [CW-1:0]     bit_cnt,
    output logic [DATA_W-1:0] addr_reg,
    output logic [DATA_W-1:0] rxb_addr
);
    logic       hold_q;
    logic       hit_data;
    logic       hit_ack;
    logic       release_now;
    hold_cfg_t  cfg;
    hold_src_t  src;
    evt_flags_t flags;
    logic       irq_q;

    assign cfg = '{stretch_dis: stretch_dis, addr_hold_en: addr_hold_en,
                   wr_hold_en: wr_hold_en, ack_hold_en: ack_hold_en};
    assign release_now = clr_hold && hold_q && !stop_evt;

    sh_frame_cnt #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .scl_fall   (scl_fall),
        .scl_rise   (scl_rise),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .holding    (hold_q),
        .release_now(release_now),
        .cnt        (bit_cnt),
        .hit_data   (hit_data),
        .hit_ack    (hit_ack)
    );

    sh_hold_decide u_dec (
        .hit_data  (hit_data),
        .hit_ack   (hit_ack),
        .cfg       (cfg),
        .rx_full   (rx_full),
        .tx_empty  (tx_empty),
        .addr_match(addr_match),
        .wr_byte   (wr_byte),
        .flags     (flags),
        .src       (src)
    );

    sh_flag_bank #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .stop_evt  (stop_evt),
        .clr_hold  (clr_hold),
        .clr_addr  (clr_addr),
        .clr_wr    (clr_wr),
        .clr_ack   (clr_ack),
        .clr_irq   (clr_irq),
        .cap_en    (hit_data && addr_match),
        .addr_sel  (addr_sel),
        .shift_byte(shift_byte),
        .hold_q    (hold_q),
        .flags     (flags),
        .irq_q     (irq_q),
        .addr_reg  (addr_reg),
        .rxb_addr  (rxb_addr)
    );

    assign scl_pull_low = hold_q;
    assign hold_flag    = hold_q;
    assign addr_flag    = flags.adr;
    assign wr_flag      = flags.wr;
    assign ack_flag     = flags.ack;
    assign irq_flag     = irq_q;
endmodule

// File: rtl/sh_stretch_chk.sv
module sh_stretch_chk #(
    parameter int FRAME_LEN = sh_pkg::FRAME_LEN,
    localparam int CW = $clog2(FRAME_LEN + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_fall,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          clr_hold,
    input logic          scl_pull_low,
    input logic          addr_flag,
    input logic          wr_flag,
    input logic          irq_flag,
    input logic [CW-1:0] bit_cnt
);
    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CW'(FRAME_LEN));

    // R1
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> bit_cnt == '0);

    // R2
    hold_needs_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull_low) |-> $past(scl_fall));

    // R6
    hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_pull_low && !clr_hold && !stop_evt) |=> scl_pull_low);

    // R9
    held_cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_pull_low && !start_evt && !stop_evt) |=> $stable(bit_cnt));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (!scl_pull_low && bit_cnt == '0));

    // R3
    addr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_flag) |-> irq_flag);

    // R4
    wr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_flag) |-> irq_flag);
endmodule

bind sh_stretch_ctrl sh_stretch_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .clr_hold    (clr_hold),
    .scl_pull_low(scl_pull_low),
    .addr_flag   (addr_flag),
    .wr_flag     (wr_flag),
    .irq_flag    (irq_flag),
    .bit_cnt     (bit_cnt)
);

// File: tb/test_sh_stretch_ctrl.sv
module test_sh_stretch_ctrl;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_fall = 0, scl_rise = 0, start_evt = 0, stop_evt = 0;
    logic rx_full = 0, tx_empty = 0, addr_match = 0, wr_byte = 0;
    logic [7:0] shift_byte = '0;
    logic stretch_dis = 0, addr_hold_en = 0, wr_hold_en = 0, ack_hold_en = 0, addr_sel = 0;
    logic clr_hold = 0, clr_addr = 0, clr_wr = 0, clr_ack = 0, clr_irq = 0;
    logic scl_pull_low, hold_flag, addr_flag, wr_flag, ack_flag, irq_flag;
    logic [CW-1:0] bit_cnt;
    logic [7:0] addr_reg, rxb_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sh_stretch_ctrl i_sh_stretch_ctrl (.*);

    // Vector fields: [10]stretch_dis [9]rx_full [8]tx_empty [7]addr_hold_en [6]addr_match
    // [5]wr_hold_en [4]wr_byte | expected [3]hold [2]addr_flag [1]wr_flag [0]irq_flag
    localparam logic [10:0] VEC [8] = '{
        11'b0_00_00_00_0000,   // nothing applies
        11'b0_10_00_00_1000,   // R2 rx full
        11'b0_01_00_00_1000,   // R2 tx empty
        11'b1_11_00_00_0000,   // R2 disabled
        11'b0_00_11_00_1101,   // R3 address hold
        11'b0_00_01_00_0000,   // R3 match without enable
        11'b0_00_00_11_1011,   // R4 write hold
        11'b0_10_11_11_1111    // R10 all at once
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_fall();
        scl_fall = 1; tick(); scl_fall = 0;
    endtask

    task automatic pulse_rise();
        scl_rise = 1; tick(); scl_rise = 0;
    endtask

    task automatic pulse_start();
        start_evt = 1; tick(); start_evt = 0;
    endtask

    task automatic clean_up();
        clr_hold = 1; clr_addr = 1; clr_wr = 1; clr_ack = 1; clr_irq = 1; stop_evt = 1;
        tick();
        clr_hold = 0; clr_addr = 0; clr_wr = 0; clr_ack = 0; clr_irq = 0; stop_evt = 0;
    endtask

    task automatic bits(int k);
        for (int j = 0; j < k; j++) begin
            pulse_fall();
            pulse_rise();
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        // reset state
        check("R1 reset cnt", 32'(bit_cnt), 0);
        check("R6 reset hold", 32'(scl_pull_low), 0);
        check("R12 reset irq", 32'(irq_flag), 0);

        for (int i = 0; i < 8; i++) begin
            logic [10:0] v;
            v = VEC[i];
            stretch_dis = v[10]; rx_full = v[9]; tx_empty = v[8];
            addr_hold_en = v[7]; addr_match = v[6]; wr_hold_en = v[5]; wr_byte = v[4];
            pulse_start();
            bits(7);
            pulse_fall();
            check("R1 cnt at 8", 32'(bit_cnt), 8);
            check("R2/R3/R4/R10 hold", 32'(scl_pull_low), 32'(v[3]));
            check("R10 hold_flag", 32'(hold_flag), 32'(v[3]));
            check("R3 addr_flag", 32'(addr_flag), 32'(v[2]));
            check("R4 wr_flag", 32'(wr_flag), 32'(v[1]));
            check("R2 irq_flag", 32'(irq_flag), 32'(v[0]));
            rx_full = 0; tx_empty = 0; addr_match = 0; wr_byte = 0;
            stretch_dis = 0; addr_hold_en = 0; wr_hold_en = 0;
            clean_up();
        end

        // R5 acknowledge-time hold
        ack_hold_en = 1;
        pulse_start();
        bits(7);
        pulse_fall();
        check("R5 no hold at 8", 32'(scl_pull_low), 0);
        pulse_rise();
        pulse_fall();
        check("R5 hold at 9", 32'(scl_pull_low), 1);
        check("R5 ack_flag", 32'(ack_flag), 1);
        check("R5 irq_flag", 32'(irq_flag), 1);
        check("R1 cnt 9", 32'(bit_cnt), 9);

        // R6 hold persists
        repeat (5) tick();
        check("R6 still held", 32'(scl_pull_low), 1);
        // R9 fall while held ignored
        pulse_fall();
        check("R9 held fall ignored", 32'(bit_cnt), 9);
        clr_hold = 1; tick(); clr_hold = 0;
        check("R6 released", 32'(scl_pull_low), 0);
        check("R6 ack_flag kept", 32'(ack_flag), 1);
        pulse_fall();
        check("R9 fall before rise ignored", 32'(bit_cnt), 9);
        pulse_rise();
        pulse_fall();
        check("R1 wrap to 1", 32'(bit_cnt), 1);

        // R7 ack flag still set: no new hold at 9
        pulse_rise();
        bits(7);
        pulse_fall();
        check("R7 cnt 9", 32'(bit_cnt), 9);
        check("R7 no rehold", 32'(scl_pull_low), 0);
        clr_ack = 1; tick(); clr_ack = 0;
        check("R12 ack cleared", 32'(ack_flag), 0);
        check("R12 irq kept", 32'(irq_flag), 1);
        clr_irq = 1; tick(); clr_irq = 0;
        check("R12 irq cleared", 32'(irq_flag), 0);
        ack_hold_en = 0;

        // R1 start mid-frame
        pulse_rise();
        bits(3);
        check("R1 mid cnt", 32'(bit_cnt), 3);
        pulse_start();
        check("R1 start zero", 32'(bit_cnt), 0);

        // R11 stop during hold
        rx_full = 1;
        bits(7);
        pulse_fall();
        check("R11 pre hold", 32'(scl_pull_low), 1);
        stop_evt = 1; tick(); stop_evt = 0;
        check("R11 stop release", 32'(scl_pull_low), 0);
        check("R11 stop cnt", 32'(bit_cnt), 0);
        rx_full = 0;

        // R8 address capture targets
        addr_sel = 0; addr_match = 1; shift_byte = 8'hA5;
        pulse_start();
        bits(7);
        pulse_fall();
        check("R8 addr_reg", 32'(addr_reg), 32'hA5);
        check("R8 rxb untouched", 32'(rxb_addr), 0);
        clean_up();
        addr_sel = 1; shift_byte = 8'h3C;
        pulse_start();
        bits(7);
        pulse_fall();
        check("R8 rxb_addr", 32'(rxb_addr), 32'h3C);
        check("R8 addr_reg kept", 32'(addr_reg), 32'hA5);
        addr_match = 0;
        clean_up();

        // R12 individual clears
        addr_hold_en = 1; wr_hold_en = 1; addr_match = 1; wr_byte = 1;
        pulse_start();
        bits(7);
        pulse_fall();
        addr_match = 0; wr_byte = 0;
        clr_addr = 1; tick(); clr_addr = 0;
        check("R12 addr cleared", 32'(addr_flag), 0);
        check("R12 wr kept", 32'(wr_flag), 1);
        check("R12 hold kept", 32'(scl_pull_low), 1);
        clean_up();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule